// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target with 7-bit addressing. It gives an external bus master byte-wide read and write access to a 256-byte storage space through an internal pointer. A write transfer first sets the pointer. Each later data byte in that transfer is stored at the pointer, and the pointer then advances. A read transfer returns the byte at the pointer and advances the pointer after every byte the master accepts.

The device address sits in a small host-side register file. At reset its two low bits are taken from strap pins, so up to four instances can share one bus. Those two bits are protected against host writes unless an unlock bit is set first. The block also acknowledges the SMBus alert response address and replies to it with its own address. It never acknowledges the all-zeros address. The block takes no part in the bus while its enable bit is clear.

SCL and SDA are sampled by the system clock through two-flop synchronisers. SDA is driven as an open-drain output enable (1 pulls the line low), and that enable only changes while SCL is low.

Top module: `i2c_ptr_target`

## Requirements
- R1: An address byte is acknowledged when the block is enabled and its upper seven bits equal the programmed device address or the alert response address 7'b0001100. The eighth bit is read/write, with 1 meaning read. Any other address is NACKed, and the block ignores the rest of that transfer.
- R2: The address 7'b0000000 is never acknowledged, even when the programmed device address is zero.
- R3: After reset the device address is {ADDR_HI_RST, strap_lo_i}, with ADDR_HI_RST defaulting to 5'b10100. Enable, unlock and the pointer all reset to 0.
- R4: The host register file has three offsets. Offset 0 holds the device address in bits 6:0. Offset 1 holds the controls: bit 0 is enable and bit 1 is unlock. A write to offset 0 always updates address bits 6:2. It updates bits 1:0 only when unlock already reads 1.
- R5: Host offset 2 reads back the current pointer. It is read-only.
- R6: While enable is 0, every address byte is NACKed and sda_oe_o stays 0.
- R7: A new device address written by the host is used from the next address phase onward.
- R8: A read at the alert response address returns {device address, 1'b0}. That byte does not move the pointer.
- R9: In a write transfer, the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then increments, wrapping from 0xFF to 0x00.
- R10: In a read transfer, the byte at the pointer is returned MSB first, and the pointer increments after each byte. When the master NACKs, the block releases SDA and goes idle.
- R11: sda_oe_o changes only while the synchronised SCL is low.
- R12: A repeated START begins a new address phase, and a STOP returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_lo_i | input | 2 | Low device-address bits, loaded at reset |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 2 | Host register offset |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for host_addr_i |

## Verification
A bit-level bus master drives several kinds of traffic:
- Write bursts at a mid-range pointer and across the 0xFF to 0x00 boundary. These tell apart a pointer that loads from one that stores its first byte.
- Read bursts after a repeated START, ending in a master NACK. These separate post-byte increment from pre-byte increment, and show whether the block releases the bus at the end.
- Address bytes that differ from the device address in one bit, the alert response address, and the zero address. These expose loose compare logic.
- Host writes to the address with the lock closed and then open. These show whether the low bits are guarded and whether the new address takes effect on the next transfer.

A behavioural byte-array model in the bench predicts every returned byte and every pointer readback.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } tgt_state_e;

  localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;

  // Decide whether a received 7-bit address is to be acknowledged.
  function automatic logic addr_hit(input logic [6:0] bus_a,
                                    input logic [6:0] own_a,
                                    input logic       en);
    return en && (bus_a != 7'd0) &&
           ((bus_a == own_a) || (bus_a == ALERT_RESP_ADDR));
  endfunction

  // Alert-response selection: only when it is not also the own address.
  function automatic logic is_alert(input logic [6:0] bus_a,
                                    input logic [6:0] own_a);
    return (bus_a == ALERT_RESP_ADDR) && (bus_a != own_a);
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  // R12
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !stop_det);

endmodule

// File: rtl/i2c_tgt_cfg.sv
module i2c_tgt_cfg #(
  parameter logic [4:0] ADDR_HI_RST = 5'b10100,
  parameter int         AW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    strap_lo,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic [AW-1:0] ptr_i,
  output logic [6:0]    dev_addr_o,
  output logic          enable_o
);
  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_PTR  = 2'd2;

  logic [6:0] dev_addr_q;
  logic       en_q, unlock_q;
  logic       addr_wr_ev, ctrl_wr_ev;

  assign addr_wr_ev = host_we && (host_addr == OFS_ADDR);
  assign ctrl_wr_ev = host_we && (host_addr == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr_q <= {ADDR_HI_RST, strap_lo};
      en_q       <= 1'b0;
      unlock_q   <= 1'b0;
    end else begin
      if (addr_wr_ev) begin
        dev_addr_q[6:2] <= host_wdata[6:2];
        if (unlock_q) dev_addr_q[1:0] <= host_wdata[1:0];
      end
      if (ctrl_wr_ev) begin
        en_q     <= host_wdata[0];
        unlock_q <= host_wdata[1];
      end
    end
  end

  always_comb begin
    unique case (host_addr)
      OFS_ADDR: host_rdata = {1'b0, dev_addr_q};
      OFS_CTRL: host_rdata = {6'd0, unlock_q, en_q};
      OFS_PTR:  host_rdata = 8'(ptr_i);
      default:  host_rdata = 8'd0;
    endcase
  end

  assign dev_addr_o = dev_addr_q;
  assign enable_o   = en_q;

  // R4
  lowbits_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr_ev && !unlock_q) |=> (dev_addr_q[1:0] == $past(dev_addr_q[1:0])));

  // R4
  highbits_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr_ev |=> (dev_addr_q[6:2] == $past(host_wdata[6:2])));

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [6:0]    dev_addr,
  input  logic          enable,
  output logic          sda_oe,
  output logic [AW-1:0] ptr_o,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int CW = 4;

  tgt_state_e    state_q;
  logic [CW-1:0] bitcnt_q;
  logic [7:0]    shreg_q, txreg_q;
  logic          rw_q, ara_q, first_q, oe_q, mack_q;
  logic [AW-1:0] ptr_q;

  // named internal events
  logic       shift_in, addr_done, addr_ack_go, wbyte_done;
  logic       ptr_load, data_wr, rbyte_done, rack_fall;
  logic [7:0] next_tx;

  assign shift_in    = scl_rise && (state_q == ST_ADDR || state_q == ST_WBYTE)
                       && (bitcnt_q < CW'(8));
  assign addr_done   = (state_q == ST_ADDR) && scl_fall && (bitcnt_q == CW'(8));
  assign addr_ack_go = addr_done && addr_hit(shreg_q[7:1], dev_addr, enable);
  assign wbyte_done  = (state_q == ST_WBYTE) && scl_fall && (bitcnt_q == CW'(8));
  assign ptr_load    = wbyte_done && first_q;
  assign data_wr     = wbyte_done && !first_q;
  assign rbyte_done  = (state_q == ST_RBYTE) && scl_fall && (bitcnt_q == CW'(7));
  assign rack_fall   = (state_q == ST_RACK) && scl_fall;
  assign next_tx     = ara_q ? {dev_addr, 1'b0} : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      txreg_q  <= '0;
      rw_q     <= 1'b0;
      ara_q    <= 1'b0;
      first_q  <= 1'b0;
      oe_q     <= 1'b0;
      mack_q   <= 1'b1;
      ptr_q    <= '0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else begin
      if (shift_in) begin
        shreg_q  <= {shreg_q[6:0], sda_s};
        bitcnt_q <= bitcnt_q + CW'(1);
      end
      unique case (state_q)
        ST_ADDR: if (addr_done) begin
          if (addr_ack_go) begin
            state_q <= ST_AACK;
            oe_q    <= 1'b1;
            rw_q    <= shreg_q[0];
            ara_q   <= is_alert(shreg_q[7:1], dev_addr);
            first_q <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_AACK: if (scl_fall) begin
          bitcnt_q <= '0;
          if (rw_q) begin
            state_q <= ST_RBYTE;
            oe_q    <= ~next_tx[7];
            txreg_q <= {next_tx[6:0], 1'b0};
          end else begin
            state_q <= ST_WBYTE;
            oe_q    <= 1'b0;
          end
        end
        ST_WBYTE: if (wbyte_done) begin
          state_q <= ST_WACK;
          oe_q    <= 1'b1;
          first_q <= 1'b0;
          if (ptr_load) ptr_q <= shreg_q[AW-1:0];
          else          ptr_q <= ptr_q + AW'(1);
        end
        ST_WACK: if (scl_fall) begin
          state_q  <= ST_WBYTE;
          oe_q     <= 1'b0;
          bitcnt_q <= '0;
        end
        ST_RBYTE: if (scl_fall) begin
          if (rbyte_done) begin
            state_q  <= ST_RACK;
            oe_q     <= 1'b0;
            bitcnt_q <= '0;
            ara_q    <= 1'b0;
            if (!ara_q) ptr_q <= ptr_q + AW'(1);
          end else begin
            oe_q     <= ~txreg_q[7];
            txreg_q  <= {txreg_q[6:0], 1'b0};
            bitcnt_q <= bitcnt_q + CW'(1);
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= sda_s;
          if (rack_fall) begin
            if (!mack_q) begin
              state_q <= ST_RBYTE;
              oe_q    <= ~next_tx[7];
              txreg_q <= {next_tx[6:0], 1'b0};
            end else begin
              state_q <= ST_IDLE;
              oe_q    <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe    = oe_q;
  assign ptr_o     = ptr_q;
  assign mem_we    = data_wr;
  assign mem_addr  = ptr_q;
  assign mem_wdata = shreg_q;

  // R2
  zero_addr_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AACK && $past(state_q) == ST_ADDR) |-> (shreg_q[7:1] != 7'd0));

  // R6
  disabled_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AACK && $past(state_q) == ST_ADDR) |-> $past(enable));

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_s) |-> $stable(oe_q));

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr_q == '1) |=> (ptr_q == '0));

  // R10
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rack_fall && mack_q && !start_det && !stop_det) |=> (!oe_q && state_q == ST_IDLE));

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target #(
  parameter logic [4:0] ADDR_HI_RST = 5'b10100,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] strap_lo_i,
  input  logic       host_we_i,
  input  logic [1:0] host_addr_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]    dev_addr;
  logic          enable;
  logic [AW-1:0] ptr;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_cfg #(.ADDR_HI_RST(ADDR_HI_RST), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .strap_lo(strap_lo_i),
    .host_we(host_we_i), .host_addr(host_addr_i), .host_wdata(host_wdata_i),
    .host_rdata(host_rdata_o), .ptr_i(ptr),
    .dev_addr_o(dev_addr), .enable_o(enable)
  );

  i2c_tgt_engine #(.AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .enable(enable), .sda_oe(sda_oe_o), .ptr_o(ptr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  i2c_tgt_regs #(.AW(AW), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr),
    .wdata(mem_wdata), .raddr(mem_addr), .rdata(mem_rdata)
  );

endmodule

// File: tb/i2c_ptr_target_bench.sv
module i2c_ptr_target_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic host_we = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0, host_rdata;
  logic [1:0] strap = 2'b10;
  wire sda_line = sda_m & ~sda_oe;

  int n_tests = 0, n_fail = 0;
  logic [7:0] ref_mem [256];
  int ref_ptr = 0;
  bit oe_seen = 0;
  int oe_viol = 0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always #10 clk = ~clk;

  i2c_ptr_target u_i2c_ptr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_lo_i(strap), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata)
  );

  // R11 / R6 monitor
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) oe_viol++;
    if (rst_n && sda_oe) oe_seen = 1;
    prev_oe  <= sda_oe;
    prev_scl <= scl_m;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic bus_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q();
  endtask

  task automatic tx_bit(input logic b);
    sda_m = b; q(); scl_m = 1; q(); scl_m = 0; q();
  endtask

  task automatic rx_bit(output logic b);
    sda_m = 1; q(); scl_m = 1; q(); b = sda_line; scl_m = 0; q();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) tx_bit(d[i]);
    rx_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rx_bit(b); d[i] = b; end
    tx_bit(!give_ack);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; #1; d = host_rdata;
  endtask

  // write burst through the reference model
  task automatic wr_burst(input logic [6:0] dev, input logic [7:0] p,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    bit ack;
    bus_start();
    send_byte({dev, 1'b0}, ack); chk("R1 write address ack", ack, 1);
    send_byte(p, ack);           chk("R9 pointer byte ack", ack, 1);
    ref_ptr = p;
    send_byte(d0, ack); ref_mem[ref_ptr] = d0; ref_ptr = (ref_ptr + 1) % 256;
    send_byte(d1, ack); ref_mem[ref_ptr] = d1; ref_ptr = (ref_ptr + 1) % 256;
    send_byte(d2, ack); ref_mem[ref_ptr] = d2; ref_ptr = (ref_ptr + 1) % 256;
    chk("R9 data ack", ack, 1);
    bus_stop();
  endtask

  // pointer set, repeated START, read three bytes (ACK, ACK, NACK)
  task automatic rd_burst(input logic [6:0] dev, input logic [7:0] p);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({dev, 1'b0}, ack);
    send_byte(p, ack);
    ref_ptr = p;
    bus_start();
    send_byte({dev, 1'b1}, ack); chk("R12 repeated start read ack", ack, 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, d);
      chk("R10 read data", d, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 256;
    end
    chk("R10 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic addr_only(input logic [6:0] dev, output bit ack);
    bus_start(); send_byte({dev, 1'b0}, ack); bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    bit ack;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    host_rd(2'd0, r); chk("R3 reset address", r, 8'h52);
    host_rd(2'd1, r); chk("R3 reset controls", r, 8'h00);
    host_rd(2'd2, r); chk("R5 reset pointer", r, 8'h00);

    oe_seen = 0;
    addr_only(7'h52, ack);
    chk("R6 disabled NACK", ack, 0);
    chk("R6 SDA untouched", oe_seen, 0);

    host_wr(2'd1, 8'h01);
    wr_burst(7'h52, 8'h10, 8'h11, 8'h22, 8'h33);
    host_rd(2'd2, r); chk("R5 pointer after write", r, ref_ptr);
    rd_burst(7'h52, 8'h10);
    host_rd(2'd2, r); chk("R5 pointer after read", r, ref_ptr);

    wr_burst(7'h52, 8'hFE, 8'hA1, 8'hA2, 8'hA3);
    host_rd(2'd2, r); chk("R9 pointer wrap", r, 8'h01);
    rd_burst(7'h52, 8'hFE);

    addr_only(7'h53, ack); chk("R1 other address NACK", ack, 0);

    bus_start();
    send_byte({7'h0C, 1'b1}, ack); chk("R8 alert address ack", ack, 1);
    recv_byte(0, r); chk("R8 alert reply", r, 8'hA4);
    bus_stop();
    host_rd(2'd2, r); chk("R8 pointer unchanged", r, ref_ptr);

    host_wr(2'd0, 8'h7D);
    host_rd(2'd0, r); chk("R4 locked low bits", r, 8'h7E);
    addr_only(7'h7E, ack); chk("R7 new address ack", ack, 1);
    addr_only(7'h52, ack); chk("R7 old address NACK", ack, 0);

    host_wr(2'd1, 8'h03);
    host_wr(2'd0, 8'h00);
    host_rd(2'd0, r); chk("R4 unlocked write", r, 8'h00);
    addr_only(7'h00, ack); chk("R2 zero address NACK", ack, 0);
    host_wr(2'd0, 8'h52);
    addr_only(7'h52, ack); chk("R7 restored address ack", ack, 1);

    chk("R11 SDA change while SCL high", oe_viol, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule